// File: doc/BRIEF.md
# Interrupt Target Routing Register Bank

This block holds, for every interrupt ID of an interrupt distributor, one byte that says which CPUs the interrupt may be delivered to. The ID is the byte offset inside the bank's address window. Requests can address either a single byte or an aligned 32-bit word that spans four consecutive IDs. The first 32 IDs are private to each CPU. Their masks are not stored, and writes that address them do nothing. When software reads one of those IDs it gets back a mask that names only the CPU doing the read.

For each shared ID (32 up to `NUM_IRQ-1`) the bank stores the written byte after clearing every bit whose CPU is not online, using the `online_cpus` count sampled when the request is accepted. From the stored mask it also registers a single delivery CPU: the index of the lowest set bit, or CPU 0 when the mask is empty. Each stored mask and its delivery index appear as flat vectors, one slot per shared ID, so that the neighbouring delivery logic can read them.

Requests travel on a valid/ready channel and responses on a second valid/ready channel. Each accepted request, read or write, produces exactly one response beat. The bank holds only one response at a time, so a response that is held back by low `rsp_ready` also holds back the request channel.

Top module: `trt_routing_bank`

## Requirements
- R1: After reset every stored mask and every delivery index is 0, and `rsp_valid` is 0.
- R2: `req_ready` equals `!rsp_valid || rsp_ready`, and each accepted request produces one response. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` holds its value.
- R3: A byte write (`req_word`=0) to shared ID `req_addr` stores `req_wdata[7:0]`, clipped as in R5, and leaves every other ID unchanged.
- R4: A word write (`req_word`=1) ignores `req_addr[1:0]`. Byte lane k (`req_wdata[8k+7:8k]`) is written to ID `(req_addr & ~3) + k`, for k = 0 to 3.
- R5: Bit b of a written mask is stored only if b < `online_cpus`. With `online_cpus`=0 an empty mask is stored.
- R6: The delivery index of a shared ID is the position of the lowest set bit of its stored mask, or 0 when the mask is empty. The index changes at the same clock edge as the mask.
- R7: Writes that address IDs 0 to 31 change no stored mask and no delivery index.
- R8: A read of an ID below 32 returns a byte with only bit `req_cpu` set.
- R9: A byte read returns the mask in `rsp_rdata[7:0]` with the upper bits 0. A word read returns ID base+k in byte lane k. A write's response data is 0.
- R10: IDs at or above `NUM_IRQ` read as 0, and writes to them have no effect. Such an address never aliases onto a stored ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| online_cpus | input | CNT_W | Number of online CPUs, used to clip written masks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_word | input | 1 | 1 for a 32-bit access, 0 for an 8-bit access |
| req_addr | input | ADDR_W | Byte offset, which is the interrupt ID |
| req_wdata | input | 32 | Write data |
| req_cpu | input | CPU_W | Index of the CPU making the access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| mask_o | output | SHARED*NUM_CPU | Stored masks; slot j belongs to ID 32+j |
| route_o | output | SHARED*CPU_W | Delivery CPU index; slot j belongs to ID 32+j |

## Verification
The bench targets these corner cases:
- **Word write with a misaligned address.** A design that honoured `req_addr[1:0]` would write the lanes to shifted IDs.
- **Clipping with few CPUs online.** A design that skipped the clip would report delivery to CPUs that do not exist, and its stored byte would read back wrong.
- **Masks with several bits set, and an empty mask.** These expose a design that picks the highest set bit, or one that leaves a stale index.
- **Writes to private IDs and to addresses past the last ID.** These catch an index that is only truncated: address 64 or 96 would then land on ID 32.
- **Held response.** If ready were not tied to the held response, a beat would be lost or its data overwritten.

// File: rtl/trt_pkg.sv
package trt_pkg;
  localparam int LANE_W     = 8;
  localparam int LANES      = 4;
  localparam int PRIVATE_ID = 32;

  typedef logic [LANE_W-1:0] lane_t;

  // Lowest set bit position; 0 for an empty byte.
  function automatic logic [2:0] lowest_cpu(input lane_t m);
    logic [2:0] r;
    r = '0;
    for (int i = LANE_W - 1; i >= 0; i--) begin
      if (m[i]) r = 3'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/trt_write_dec.sv
module trt_write_dec
  import trt_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 4,
  localparam int SHARED = NUM_IRQ - PRIVATE_ID
) (
  input  logic                        wr_fire,
  input  logic                        word,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANES*LANE_W-1:0]     wdata,
  input  logic [CNT_W-1:0]            online,
  output logic [SHARED-1:0]           we,
  output logic [SHARED*NUM_CPU-1:0]   wmask
);
  logic [NUM_CPU-1:0] online_mask;

  for (genvar b = 0; b < NUM_CPU; b++) begin : g_online
    assign online_mask[b] = (online > CNT_W'(b));
  end

  for (genvar j = 0; j < SHARED; j++) begin : g_ent
    localparam int ID   = PRIVATE_ID + j;
    localparam int LANE = ID % LANES;
    logic  hit_byte, hit_word;
    lane_t raw;
    assign hit_byte = !word && (addr == ADDR_W'(ID));
    assign hit_word =  word && (addr[ADDR_W-1:2] == (ADDR_W-2)'(ID / LANES));
    assign raw      = word ? wdata[LANE*LANE_W +: LANE_W] : wdata[LANE_W-1:0];
    assign we[j]    = wr_fire && (hit_byte || hit_word);
    assign wmask[j*NUM_CPU +: NUM_CPU] = raw[NUM_CPU-1:0] & online_mask;
  end
endmodule

// File: rtl/trt_entry.sv
module trt_entry
  import trt_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NUM_CPU-1:0] wmask,
  output logic [NUM_CPU-1:0] mask_q,
  output logic [CPU_W-1:0]   route_q
);
  logic [2:0] first;
  assign first = lowest_cpu(LANE_W'(wmask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (we) begin
      mask_q  <= wmask;
      route_q <= CPU_W'(first);
    end
  end
endmodule

// File: rtl/trt_read_mux.sv
module trt_read_mux
  import trt_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3,
  parameter int ADDR_W  = 8,
  localparam int SHARED = NUM_IRQ - PRIVATE_ID,
  localparam int SIDX_W = (SHARED > 1) ? $clog2(SHARED) : 1
) (
  input  logic                      word,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CPU_W-1:0]          cpu,
  input  logic [SHARED*NUM_CPU-1:0] masks,
  output logic [LANES*LANE_W-1:0]   rdata
);
  logic [NUM_CPU-1:0] mask_arr [SHARED];
  lane_t own;

  for (genvar j = 0; j < SHARED; j++) begin : g_arr
    assign mask_arr[j] = masks[j*NUM_CPU +: NUM_CPU];
  end

  assign own = lane_t'(1) << cpu;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W-1:0] id;
    logic              en;
    assign en = word || (k == 0);
    assign id = word ? {addr[ADDR_W-1:2], 2'(k)} : addr;
    always_comb begin
      if (!en)
        rdata[k*LANE_W +: LANE_W] = '0;
      else if (id < ADDR_W'(PRIVATE_ID))
        rdata[k*LANE_W +: LANE_W] = own;
      else if (id < ADDR_W'(NUM_IRQ))
        rdata[k*LANE_W +: LANE_W] =
          LANE_W'(mask_arr[SIDX_W'(id - ADDR_W'(PRIVATE_ID))]);
      else
        rdata[k*LANE_W +: LANE_W] = '0;
    end
  end
endmodule

// File: rtl/trt_routing_bank.sv
module trt_routing_bank
  import trt_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8,
  parameter int ADDR_W  = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W  = $clog2(NUM_CPU + 1),
  localparam int SHARED = NUM_IRQ - PRIVATE_ID
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          online_cpus,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic                      req_word,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [31:0]               req_wdata,
  input  logic [CPU_W-1:0]          req_cpu,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [31:0]               rsp_rdata,
  output logic [SHARED*NUM_CPU-1:0] mask_o,
  output logic [SHARED*CPU_W-1:0]   route_o
);
  logic                      accept;
  logic [SHARED-1:0]         we;
  logic [SHARED*NUM_CPU-1:0] wmask;
  logic [31:0]               rd_comb;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  trt_write_dec #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_wdec (
    .wr_fire(accept && req_write),
    .word   (req_word),
    .addr   (req_addr),
    .wdata  (req_wdata),
    .online (online_cpus),
    .we     (we),
    .wmask  (wmask)
  );

  for (genvar j = 0; j < SHARED; j++) begin : g_entry
    trt_entry #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we[j]),
      .wmask  (wmask[j*NUM_CPU +: NUM_CPU]),
      .mask_q (mask_o[j*NUM_CPU +: NUM_CPU]),
      .route_q(route_o[j*CPU_W +: CPU_W])
    );
  end

  trt_read_mux #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)
  ) u_rmux (
    .word (req_word),
    .addr (req_addr),
    .cpu  (req_cpu),
    .masks(mask_o),
    .rdata(rd_comb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_comb;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trt_routing_checker.sv
module trt_routing_checker #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8,
  parameter int ADDR_W  = 8,
  parameter int CPU_W   = 3,
  localparam int SHARED = NUM_IRQ - 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_write,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [31:0]               rsp_rdata,
  input logic [SHARED*NUM_CPU-1:0] mask_o,
  input logic [SHARED*CPU_W-1:0]   route_o
);
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(mask_o) && $stable(route_o));

  p_private_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (req_addr < ADDR_W'(32)))
      |=> $stable(mask_o) && $stable(route_o));

  for (genvar j = 0; j < SHARED; j++) begin : g_chk
    logic [NUM_CPU-1:0] m;
    logic [CPU_W-1:0]   r;
    assign m = mask_o[j*NUM_CPU +: NUM_CPU];
    assign r = route_o[j*CPU_W +: CPU_W];

    p_route_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (m != '0) |-> (m[r] && ((m & ((NUM_CPU'(1) << r) - NUM_CPU'(1))) == '0)));

    p_route_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (m == '0) |-> (r == '0));
  end
endmodule

bind trt_routing_bank trt_routing_checker #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .mask_o   (mask_o),
  .route_o  (route_o)
);

// File: tb/tb_trt_routing_bank.sv
`timescale 1ns/1ps
module tb_trt_routing_bank;
  localparam int NUM_IRQ = 64;
  localparam int NUM_CPU = 8;
  localparam int ADDR_W  = 8;
  localparam int CPU_W   = 3;
  localparam int CNT_W   = 4;
  localparam int SHARED  = NUM_IRQ - 32;

  logic clk = 0;
  logic rst_n = 0;
  logic [CNT_W-1:0] online_cpus = 4'd8;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [CPU_W-1:0] req_cpu = '0;
  logic rsp_valid;
  logic rsp_ready = 1;
  logic [31:0] rsp_rdata;
  logic [SHARED*NUM_CPU-1:0] mask_o;
  logic [SHARED*CPU_W-1:0] route_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mask [SHARED];

  always #10 clk = ~clk;

  trt_routing_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .online_cpus(online_cpus),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .mask_o(mask_o), .route_o(route_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_route(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return 3'(i);
    return 3'd0;
  endfunction

  // Compare every slot against the model (R6 lowest-bit rule included).
  task automatic check_all(input string tag);
    for (int j = 0; j < SHARED; j++) begin
      chk({tag, " mask"}, 32'(mask_o[j*NUM_CPU +: NUM_CPU]), 32'(exp_mask[j]));
      chk({tag, " R6 route"}, 32'(route_o[j*CPU_W +: CPU_W]), 32'(exp_route(exp_mask[j])));
    end
  endtask

  function automatic logic [7:0] clip(input logic [7:0] v);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = v[b] && (b < int'(online_cpus));
    return m;
  endfunction

  task automatic model_write(input logic wd, input int a, input logic [31:0] d);
    if (wd) begin
      for (int k = 0; k < 4; k++) begin
        int id = (a & ~3) + k;
        if (id >= 32 && id < NUM_IRQ) exp_mask[id-32] = clip(d[8*k +: 8]);
      end
    end else if (a >= 32 && a < NUM_IRQ) exp_mask[a-32] = clip(d[7:0]);
  endtask

  task automatic do_req(input logic wr, input logic wd, input int a,
                        input logic [31:0] d, input int c, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = wd;
    req_addr = ADDR_W'(a); req_wdata = d; req_cpu = CPU_W'(c);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata;
    if (wr) model_write(wd, a, d);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    check_all("R1 reset");
  endtask

  task automatic t_byte_write();
    logic [31:0] rd;
    do_req(1, 0, 40, 32'hFFFF_FF28, 0, rd);
    chk("R9 write rsp data", rd, 0);
    check_all("R3 byte write");
    chk("R6 route id40", 32'(route_o[8*CPU_W +: CPU_W]), 3);
    do_req(0, 0, 40, 0, 0, rd);
    chk("R9 byte read", rd, 32'h0000_0028);
  endtask

  task automatic t_word_write();
    logic [31:0] rd;
    do_req(1, 1, 45, 32'h8001_0006, 0, rd);
    check_all("R4 word write");
    chk("R4 id47 route", 32'(route_o[15*CPU_W +: CPU_W]), 7);
    do_req(0, 1, 46, 0, 0, rd);
    chk("R9 word read", rd, 32'h8001_0006);
  endtask

  task automatic t_clip();
    logic [31:0] rd;
    online_cpus = 4'd3;
    do_req(1, 0, 33, 32'h0000_00F8, 0, rd);
    do_req(1, 0, 34, 32'h0000_00FC, 0, rd);
    do_req(1, 1, 48, 32'hFFFF_FFFF, 0, rd);
    check_all("R5 clip");
    chk("R5 id34", 32'(mask_o[2*NUM_CPU +: NUM_CPU]), 32'h04);
    do_req(1, 0, 40, 32'h0000_0000, 0, rd);
    chk("R6 empty route", 32'(route_o[8*CPU_W +: CPU_W]), 0);
    online_cpus = 4'd0;
    do_req(1, 0, 50, 32'h0000_00FF, 0, rd);
    chk("R5 zero online", 32'(mask_o[18*NUM_CPU +: NUM_CPU]), 0);
    online_cpus = 4'd8;
  endtask

  task automatic t_private();
    logic [31:0] rd;
    do_req(1, 1, 0, 32'hFFFF_FFFF, 0, rd);
    do_req(1, 0, 31, 32'h0000_00FF, 0, rd);
    do_req(1, 1, 28, 32'h5555_5555, 0, rd);
    check_all("R7 private write");
    do_req(0, 1, 8, 0, 5, rd);
    chk("R8 private word read", rd, 32'h2020_2020);
    do_req(0, 0, 31, 0, 0, rd);
    chk("R8 private byte read", rd, 32'h0000_0001);
  endtask

  task automatic t_oob();
    logic [31:0] rd;
    do_req(1, 0, 32, 32'h0000_0011, 0, rd);
    do_req(1, 1, 64, 32'hFFFF_FFFF, 0, rd);
    do_req(1, 0, 96, 32'h0000_00EE, 0, rd);
    do_req(1, 0, 200, 32'h0000_00FF, 0, rd);
    check_all("R10 oob write");
    do_req(0, 1, 96, 0, 0, rd);
    chk("R10 oob word read", rd, 0);
    do_req(0, 0, 64, 0, 0, rd);
    chk("R10 oob byte read", rd, 0);
    do_req(0, 0, 32, 0, 0, rd);
    chk("R10 id32 intact", rd, 32'h11);
  endtask

  task automatic t_backpressure();
    logic [31:0] rd;
    rsp_ready = 0;
    do_req(0, 0, 32, 0, 0, rd);
    chk("R2 rsp valid", 32'(rsp_valid), 1);
    chk("R2 ready low", 32'(req_ready), 0);
    req_valid = 1; req_write = 0; req_word = 1; req_addr = 8'd44; req_cpu = 0;
    repeat (3) @(negedge clk);
    chk("R2 held valid", 32'(rsp_valid), 1);
    chk("R2 held data", rsp_rdata, 32'h11);
    chk("R2 still not ready", 32'(req_ready), 0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R2 next rsp valid", 32'(rsp_valid), 1);
    chk("R2 next rsp data", rsp_rdata, 32'h8001_0006);
    @(negedge clk);
    chk("R2 drained", 32'(rsp_valid), 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < SHARED; j++) exp_mask[j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_word_write();
    t_clip();
    t_private();
    t_oob();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule